// File: doc/BRIEF.md
# Hourly Chime and Alarm Sounder

This block sits beside the counters of a 24-hour clock and decides when the clock should make a sound. It reads the current time as six BCD digits, keeps its own settable alarm time, and drives one speaker line.

Two sound windows are tracked independently, each by a two-state machine with the states `WIN_IDLE` and `WIN_RING`:

- **Hourly chime.** It takes the transition `go` (`WIN_IDLE` to `WIN_RING`) when minutes and seconds both read zero. It takes the transition `done` (`WIN_RING` back to `WIN_IDLE`) when the time reads minute 01, second 20.
- **Alarm.** It takes `go` when the alarm is enabled and the hour and minute equal the stored alarm time. It takes `done` as soon as that stops being true. This happens when the minute moves on, or when the alarm is disabled.

The alarm time is advanced by two adjust inputs, one for the hour and one for the minute. Each one steps its field once per clock cycle while it is held high. The speaker is high only while a window is open and both tone inputs are high. The two tone inputs are a slow beat of about 1 Hz and an audio tone of about 1 kHz, so the sound comes out as short bursts of tone.

Top module: `clock_alert_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it, both windows are closed. The stored alarm time reads 00:00 and `spk` is low.
- R2: Each clock with `adj_hour` high advances the stored hour by one in BCD. It wraps from 23 to 00. The hour is carried in `alarm_time[15:8]`: tens digit in [15:12], units digit in [11:8].
- R3: Each clock with `adj_min` high advances the stored minute by one in BCD. It wraps from 59 to 00. The minute is carried in `alarm_time[7:0]`: tens digit in [7:4], units digit in [3:0].
- R4: `now_bcd` holds {hour tens, hour units, minute tens, minute units, second tens, second units}, four bits per digit, hour tens in [23:20]. When minutes and seconds are all zero, `chime_on` is high on the next clock.
- R5: Once open, the chime window stays open until the time reads minute 01, second 20. It closes on the clock after that.
- R6: When `alarm_en` is high and the hour and minute of `now_bcd` equal `alarm_time`, `alarm_on` is high on the next clock. All four digits are compared.
- R7: The alarm window closes on the clock after the hour and minute of `now_bcd` stop matching `alarm_time`.
- R8: With `alarm_en` low, `alarm_on` is low from the next clock on, and only the chime can sound.
- R9: `spk` equals (`chime_on` OR `alarm_on`) AND `tone_slow` AND `tone_fast`, with no added delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low clear |
| now_bcd | input | 24 | Current time as six BCD digits |
| adj_hour | input | 1 | Step the alarm hour each clock while high |
| adj_min | input | 1 | Step the alarm minute each clock while high |
| alarm_en | input | 1 | Allows the alarm window to open |
| tone_slow | input | 1 | Slow beat clock, about 1 Hz |
| tone_fast | input | 1 | Audio tone clock, about 1 kHz |
| alarm_time | output | 16 | Stored alarm hour and minute, BCD |
| chime_on | output | 1 | Hourly chime window open |
| alarm_on | output | 1 | Alarm window open |
| spk | output | 1 | Speaker drive |

## Verification
The assertions assume that `now_bcd` always carries a legal time: hours 00 to 23, minutes and seconds 00 to 59, and every digit 0 to 9. They also assume that both tone inputs are plain levels sampled against `clk`. The stimulus therefore only applies legal BCD times. It drives every input on the falling edge, so each registered window is seen a full cycle after its cause, and the tone inputs are changed only while a window's state is already settled.

// File: rtl/clock_alert_pkg.sv
package clock_alert_pkg;

    localparam int DIG_W  = 4;
    localparam int PAIR_W = 2 * DIG_W;

    typedef logic [PAIR_W-1:0] bcd_pair_t;

    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_RING = 1'b1
    } win_state_e;

    // Advance a two-digit BCD value by one, returning to zero after `last`.
    function automatic bcd_pair_t bcd_pair_step(input bcd_pair_t v, input bcd_pair_t last);
        bcd_pair_t r;
        if (v == last) begin
            r = '0;
        end else if (v[DIG_W-1:0] == 4'd9) begin
            r = {v[PAIR_W-1:DIG_W] + 4'd1, 4'd0};
        end else begin
            r = {v[PAIR_W-1:DIG_W], v[DIG_W-1:0] + 4'd1};
        end
        return r;
    endfunction

endpackage

// File: rtl/alarm_preset.sv
module alarm_preset
    import clock_alert_pkg::*;
#(
    parameter bcd_pair_t HOUR_LAST = 8'h23,
    parameter bcd_pair_t MIN_LAST  = 8'h59
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      step_hour,
    input  logic      step_min,
    output bcd_pair_t hour_q,
    output bcd_pair_t min_q
);

    localparam int NFIELD = 2;

    logic [NFIELD-1:0] step;
    bcd_pair_t         last  [NFIELD];
    bcd_pair_t         field [NFIELD];

    assign step[0] = step_hour;
    assign step[1] = step_min;
    assign last[0] = HOUR_LAST;
    assign last[1] = MIN_LAST;

    // One wrapping BCD counter per field of the stored alarm time.
    for (genvar i = 0; i < NFIELD; i++) begin : g_field
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                field[i] <= '0;
            end else if (step[i]) begin
                field[i] <= bcd_pair_step(field[i], last[i]);
            end
        end
    end

    assign hour_q = field[0];
    assign min_q  = field[1];

endmodule

// File: rtl/sound_window.sv
module sound_window
    import clock_alert_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic done,
    output logic open_q
);

    win_state_e state, state_nx;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WIN_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state: go opens the window, done closes it.
    always_comb begin
        state_nx = state;
        unique case (state)
            WIN_IDLE: if (go)   state_nx = WIN_RING;
            WIN_RING: if (done) state_nx = WIN_IDLE;
            default:            state_nx = WIN_IDLE;
        endcase
    end

    // The open flag comes straight from the registered state.
    always_comb begin
        open_q = (state == WIN_RING);
    end

endmodule

// File: rtl/clock_alert_ctrl.sv
module clock_alert_ctrl
    import clock_alert_pkg::*;
#(
    parameter bcd_pair_t CHIME_END_MIN = 8'h01,
    parameter bcd_pair_t CHIME_END_SEC = 8'h20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [23:0] now_bcd,
    input  logic        adj_hour,
    input  logic        adj_min,
    input  logic        alarm_en,
    input  logic        tone_slow,
    input  logic        tone_fast,
    output logic [15:0] alarm_time,
    output logic        chime_on,
    output logic        alarm_on,
    output logic        spk
);

    bcd_pair_t now_h, now_m, now_s;
    bcd_pair_t pre_h, pre_m;

    logic top_of_hour, chime_end, alarm_hit;

    assign now_h = now_bcd[3*PAIR_W-1:2*PAIR_W];
    assign now_m = now_bcd[2*PAIR_W-1:PAIR_W];
    assign now_s = now_bcd[PAIR_W-1:0];

    alarm_preset #(
        .HOUR_LAST(8'h23),
        .MIN_LAST (8'h59)
    ) u_preset (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_hour(adj_hour),
        .step_min (adj_min),
        .hour_q   (pre_h),
        .min_q    (pre_m)
    );

    assign top_of_hour = (now_m == '0) && (now_s == '0);
    assign chime_end   = (now_m == CHIME_END_MIN) && (now_s == CHIME_END_SEC);
    assign alarm_hit   = alarm_en && (now_h == pre_h) && (now_m == pre_m);

    sound_window u_chime (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (top_of_hour),
        .done  (chime_end),
        .open_q(chime_on)
    );

    sound_window u_alarm (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (alarm_hit),
        .done  (!alarm_hit),
        .open_q(alarm_on)
    );

    assign alarm_time = {pre_h, pre_m};

    // Only the registered window flags and the two tone levels reach the speaker.
    assign spk = (chime_on || alarm_on) && tone_slow && tone_fast;

endmodule

// File: rtl/clock_alert_chk.sv
module clock_alert_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [23:0] now_bcd,
    input logic        adj_hour,
    input logic        adj_min,
    input logic        alarm_en,
    input logic        tone_slow,
    input logic        tone_fast,
    input logic [15:0] alarm_time,
    input logic        chime_on,
    input logic        alarm_on,
    input logic        spk
);

    // R2: the stored hour wraps from 23 to 00.
    p_hour_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_hour && alarm_time[15:8] == 8'h23) |=> (alarm_time[15:8] == 8'h00));

    // R3: the stored minute wraps from 59 to 00.
    p_min_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_min && alarm_time[7:0] == 8'h59) |=> (alarm_time[7:0] == 8'h00));

    // R2, R3: the stored alarm time never leaves the legal range.
    p_preset_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_time[15:8] <= 8'h23) && (alarm_time[11:8] <= 4'd9) &&
        (alarm_time[7:4] <= 4'd5) && (alarm_time[3:0] <= 4'd9));

    // R4: minutes and seconds all zero open the chime window.
    p_chime_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (now_bcd[15:0] == 16'h0000) |=> chime_on);

    // R5: the chime window closes at minute 01, second 20.
    p_chime_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (now_bcd[15:0] == 16'h0120) |=> !chime_on);

    // R6: an enabled hour and minute match opens the alarm window.
    p_alarm_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_en && now_bcd[23:8] == alarm_time) |=> alarm_on);

    // R7: a mismatch closes the alarm window.
    p_alarm_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (now_bcd[23:8] != alarm_time) |=> !alarm_on);

    // R8: a disabled alarm never sounds.
    p_alarm_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_en |=> !alarm_on);

    // R9: the speaker is silent when no window is open or a tone level is low.
    p_spk_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(chime_on || alarm_on) || !tone_slow || !tone_fast) |-> !spk);

endmodule

bind clock_alert_ctrl clock_alert_chk u_chk (.*);

// File: tb/sim_clock_alert_ctrl.sv
`timescale 1ns/1ps
module sim_clock_alert_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] now_bcd = 24'h123456;
    logic        adj_hour = 1'b0, adj_min = 1'b0, alarm_en = 1'b0;
    logic        tone_slow = 1'b0, tone_fast = 1'b0;
    logic [15:0] alarm_time;
    logic        chime_on, alarm_on, spk;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;   // 50 MHz

    clock_alert_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .now_bcd(now_bcd),
        .adj_hour(adj_hour), .adj_min(adj_min), .alarm_en(alarm_en),
        .tone_slow(tone_slow), .tone_fast(tone_fast),
        .alarm_time(alarm_time), .chime_on(chime_on),
        .alarm_on(alarm_on), .spk(spk)
    );

    // Each row: {now_bcd, alarm_en, expected chime_on, expected alarm_on}, with the alarm time set to 07:30.
    localparam logic [26:0] VEC [0:13] = '{
        {24'h065959, 1'b1, 1'b0, 1'b0},  // R4: no chime before the hour
        {24'h070000, 1'b1, 1'b1, 1'b0},  // R4: chime opens
        {24'h070119, 1'b1, 1'b1, 1'b0},  // R5: still open
        {24'h070120, 1'b1, 1'b0, 1'b0},  // R5: closes
        {24'h072959, 1'b1, 1'b0, 1'b0},  // R6: not yet
        {24'h073000, 1'b1, 1'b0, 1'b1},  // R6: alarm opens
        {24'h073045, 1'b1, 1'b0, 1'b1},  // R6: stays open
        {24'h073100, 1'b1, 1'b0, 1'b0},  // R7: next minute closes
        {24'h073010, 1'b0, 1'b0, 1'b0},  // R8: disabled
        {24'h080000, 1'b1, 1'b1, 1'b0},  // R4: next hour
        {24'h080030, 1'b1, 1'b1, 1'b0},  // R5: open
        {24'h080120, 1'b1, 1'b0, 1'b0},  // R5: close
        {24'h173000, 1'b1, 1'b0, 1'b0},  // R6: hour tens differ
        {24'h073005, 1'b1, 1'b0, 1'b1}   // R6: reopens
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : stim
        tick(2);
        // R1: state while the clear is held.
        check("R1 chime", {15'd0, chime_on}, 16'd0);
        check("R1 alarm", {15'd0, alarm_on}, 16'd0);
        check("R1 preset", alarm_time, 16'h0000);
        rst_n = 1'b1;
        tick(1);
        check("R1 spk", {15'd0, spk}, 16'd0);

        // R2: 23 hour steps, then one step that wraps.
        adj_hour = 1'b1; tick(23); adj_hour = 1'b0;
        check("R2 hour 23", alarm_time, 16'h2300);
        adj_hour = 1'b1; tick(1); adj_hour = 1'b0;
        check("R2 hour wrap", alarm_time, 16'h0000);
        // R3: 59 minute steps, then one step that wraps.
        adj_min = 1'b1; tick(59); adj_min = 1'b0;
        check("R3 min 59", alarm_time, 16'h0059);
        adj_min = 1'b1; tick(1); adj_min = 1'b0;
        check("R3 min wrap", alarm_time, 16'h0000);
        // Set the alarm to 07:30.
        adj_hour = 1'b1; tick(7); adj_hour = 1'b0;
        adj_min = 1'b1; tick(30); adj_min = 1'b0;
        check("R2 R3 preset", alarm_time, 16'h0730);

        foreach (VEC[i]) begin
            now_bcd  = VEC[i][26:3];
            alarm_en = VEC[i][2];
            tick(1);
            check($sformatf("R4-7 row %0d chime", i), {15'd0, chime_on}, {15'd0, VEC[i][1]});
            check($sformatf("R6 R7 R8 row %0d alarm", i), {15'd0, alarm_on}, {15'd0, VEC[i][0]});
        end

        // R8: dropping the enable closes a ringing alarm.
        alarm_en = 1'b0; tick(1);
        check("R8 drop", {15'd0, alarm_on}, 16'd0);

        // R9: speaker gating, with the chime window open.
        now_bcd = 24'h100000; tick(1);
        tone_slow = 1'b1; tone_fast = 1'b1; #1;
        check("R9 both high", {15'd0, spk}, 16'd1);
        tone_slow = 1'b0; #1;
        check("R9 slow low", {15'd0, spk}, 16'd0);
        tone_slow = 1'b1; tone_fast = 1'b0; #1;
        check("R9 fast low", {15'd0, spk}, 16'd0);
        tone_fast = 1'b1;
        now_bcd = 24'h100120; tick(1);
        check("R9 no window", {15'd0, spk}, 16'd0);

        // R1: a clear during a chime closes it and resets the alarm time.
        now_bcd = 24'h110000; tick(1);
        check("R4 reopen", {15'd0, chime_on}, 16'd1);
        rst_n = 1'b0; #1;
        check("R1 clear chime", {15'd0, chime_on}, 16'd0);
        check("R1 clear preset", alarm_time, 16'h0000);
        now_bcd = 24'h110500;
        tick(1); rst_n = 1'b1; tick(1);
        check("R1 after clear", {15'd0, spk}, 16'd0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule